// File: doc/BRIEF.md
# Capture Mode and Trigger Controller

This block runs acquisition into a circular sample memory. A single byte-wide mode write turns memory writing and reading on or off, arms the trigger, fires a software trigger, forces capture to a halt, clears the trigger bookkeeping or pulses a memory-initialise strobe. A trigger-match pulse arrives from separate pattern-matching logic. The current memory write address arrives from the memory writer.

When a trigger is accepted, the controller latches the write address as the trigger position. It then counts down a post-trigger length measured in memory rows. When the count runs out, it latches the stop position and ends capture. Wrapping of the write address, acceptance of a trigger and completion of the post-trigger phase each set their own sticky status flag. The status byte and both positions can be read one byte at a time through a small read selector.

The controller is a four-state machine:
- `ST_IDLE`: memory writing is off.
- `ST_RUN`: capture is running and waiting for a trigger.
- `ST_POST`: the trigger has been taken and the row countdown is running.
- `ST_STOP`: capture has ended and the stop position is held.

The transitions are:
- IDLE→RUN and STOP→RUN on a mode write with write enable set and force stop clear.
- RUN→POST when a trigger is accepted and the post length is non-zero.
- RUN→STOP when a trigger is accepted and the post length is zero, or on a force stop.
- POST→STOP when the countdown reaches zero, or on a force stop.
- RUN/POST/STOP→IDLE on a mode write with write enable clear.
- POST/STOP→RUN on a trigger-reset write with write enable set.

Top module: `capture_ctrl`

## Requirements
- R1: After reset, the status byte is 0x00, `mem_wr_en`, `mem_rd_en` and `mem_init` are low, and every position byte reads 0x00.
- R2: Each mode write loads read enable (bit 1) and trigger enable (bit 3) from the written byte. Bit 0 selects capture running or idle, subject to the force-stop and trigger rules. Bit 6 has no effect. The status byte layout is: bit 0 write enable, bit 1 read enable, bit 3 trigger enable, bit 4 wrapped, bit 5 triggered, bit 6 post-trigger complete. Status bits 2 and 7 read 0.
- R3: A trigger is accepted only in RUN while trigger enable is set. A trigger is either a `trig_hit` pulse, or a mode write with bit 5 set that also has bit 3 set. Triggers in any other state, or with trigger enable clear, change nothing. An accepted trigger sets the triggered flag and latches `wr_addr` as the trigger position.
- R4: The post-trigger length (`post_wr`) is in rows, where the row is `wr_addr[23:9]`. In POST, each cycle in which the row differs from the previous cycle's row decrements the count. The step that reaches zero moves to STOP, sets the post-complete flag and latches the stop position. A length of zero stops on the trigger cycle itself.
- R5: A mode write with bit 4 set in RUN or POST moves to STOP. `mem_wr_en` is low from the next cycle, and the stop position is the `wr_addr` seen on that write cycle.
- R6: The wrapped flag sets when `wr_addr` goes from all ones to zero while capture runs (RUN or POST). A wrap while idle or stopped does not set it.
- R7: A mode write with bit 2 set clears the wrapped, triggered and post-complete flags.
- R8: A mode write with bit 7 set produces a single-cycle `mem_init` pulse in the following cycle.
- R9: `rd_byte` is selected by `rd_sel`: 0, 1 and 2 give the trigger position low, middle and upper byte; 3, 4 and 5 give the stop position bytes in the same order; 6 gives the status byte; 7 gives 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode byte write strobe |
| mode_wdata | input | 8 | Mode byte |
| post_wr | input | 1 | Post-trigger length write strobe |
| post_wdata | input | 15 | Post-trigger length in rows |
| trig_hit | input | 1 | Trigger-match pulse from pattern logic |
| wr_addr | input | 24 | Current memory write address |
| rd_sel | input | 3 | Readback byte selector |
| rd_byte | output | 8 | Selected readback byte |
| status | output | 8 | Status byte |
| mem_wr_en | output | 1 | Memory write enable (RUN or POST) |
| mem_rd_en | output | 1 | Memory read enable |
| mem_init | output | 1 | Memory initialise pulse |

## Verification
A wrong state shows up as a status byte or `mem_wr_en` value that is off on the cycle right after the event that should have moved it. The bench samples exactly there.

A miscounted row countdown appears as a stop that comes one row early or one row late. The bench catches this by checking the status byte both before and after the final row step. A wrong latch strobe shows as wrong position bytes as soon as the position is read back. A trigger that is accepted when it should be ignored overwrites the trigger position, and the next readback exposes it.

// File: rtl/capctl_pkg.sv
package capctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_POST = 2'd2,
        ST_STOP = 2'd3
    } cap_state_e;

    // mode write bit positions
    localparam int MB_WEN    = 0;
    localparam int MB_REN    = 1;
    localparam int MB_TRST   = 2;
    localparam int MB_TEN    = 3;
    localparam int MB_FSTOP  = 4;
    localparam int MB_SWTRIG = 5;
    localparam int MB_INIT   = 7;

    // status bit positions
    localparam int SB_WEN   = 0;
    localparam int SB_REN   = 1;
    localparam int SB_TEN   = 3;
    localparam int SB_ROUND = 4;
    localparam int SB_TRIG  = 5;
    localparam int SB_POST  = 6;
endpackage

// File: rtl/capctl_addr_watch.sv
module capctl_addr_watch #(
    parameter int ADDR_W = 24,
    parameter int EVT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              row_step,
    output logic              wrap_step
);
    localparam int ROW_LSB = EVT_W;

    logic [ADDR_W-1:0] prev_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_addr <= '0;
        else        prev_addr <= wr_addr;
    end

    assign row_step  = prev_addr[ADDR_W-1:ROW_LSB] != wr_addr[ADDR_W-1:ROW_LSB];
    assign wrap_step = (&prev_addr) && (wr_addr == '0);
endmodule

// File: rtl/capctl_fsm.sv
module capctl_fsm
    import capctl_pkg::*;
#(
    parameter int POST_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [7:0]        mode_wdata,
    input  logic              post_wr,
    input  logic [POST_W-1:0] post_wdata,
    input  logic              trig_hit,
    input  logic              row_step,
    input  logic              wrap_step,
    output logic              mem_wr_en,
    output logic              mem_rd_en,
    output logic              mem_init,
    output logic [7:0]        status,
    output logic              trig_latch,
    output logic              stop_latch
);
    cap_state_e state, nstate;
    logic ren_q, ten_q, round_q, trgd_q, pdone_q;
    logic [POST_W-1:0] post_rows, cnt;

    logic capturing, w_wen, w_trst, w_fstop, w_sw, w_ten;
    logic force_go, trig_go, zero_post, post_end;

    assign capturing = (state == ST_RUN) || (state == ST_POST);
    assign w_wen     = mode_wdata[MB_WEN];
    assign w_trst    = mode_wr && mode_wdata[MB_TRST];
    assign w_fstop   = mode_wdata[MB_FSTOP];
    assign w_sw      = mode_wdata[MB_SWTRIG];
    assign w_ten     = mode_wdata[MB_TEN];
    assign zero_post = (post_rows == '0);

    assign force_go = mode_wr && w_fstop && capturing;
    assign trig_go  = (state == ST_RUN) && !trgd_q &&
                      ((mode_wr && !w_fstop && !mode_wdata[MB_TRST] && w_sw && w_ten) ||
                       (!mode_wr && ten_q && trig_hit));
    assign post_end = (state == ST_POST) && !mode_wr && row_step && (cnt == POST_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (mode_wr && w_wen && !w_fstop) nstate = ST_RUN;
            end
            ST_RUN: begin
                if (force_go)                   nstate = ST_STOP;
                else if (w_trst)                nstate = w_wen ? ST_RUN : ST_IDLE;
                else if (trig_go)               nstate = zero_post ? ST_STOP : ST_POST;
                else if (mode_wr && !w_wen)     nstate = ST_IDLE;
            end
            ST_POST: begin
                if (force_go)                   nstate = ST_STOP;
                else if (w_trst)                nstate = w_wen ? ST_RUN : ST_IDLE;
                else if (mode_wr && !w_wen)     nstate = ST_IDLE;
                else if (post_end)              nstate = ST_STOP;
            end
            ST_STOP: begin
                if (mode_wr && w_wen && !w_fstop) nstate = ST_RUN;
                else if (mode_wr && !w_wen)       nstate = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        mem_wr_en  = capturing;
        mem_rd_en  = ren_q;
        trig_latch = trig_go;
        stop_latch = force_go || (trig_go && zero_post) || post_end;
        status     = '0;
        status[SB_WEN]   = capturing;
        status[SB_REN]   = ren_q;
        status[SB_TEN]   = ten_q;
        status[SB_ROUND] = round_q;
        status[SB_TRIG]  = trgd_q;
        status[SB_POST]  = pdone_q;
    end

    // flags, counters and mode fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ren_q     <= 1'b0;
            ten_q     <= 1'b0;
            mem_init  <= 1'b0;
            round_q   <= 1'b0;
            trgd_q    <= 1'b0;
            pdone_q   <= 1'b0;
            post_rows <= '0;
            cnt       <= '0;
        end else begin
            mem_init <= mode_wr && mode_wdata[MB_INIT];
            if (mode_wr) begin
                ren_q <= mode_wdata[MB_REN];
                ten_q <= w_ten;
            end
            if (w_trst) begin
                round_q <= 1'b0;
                trgd_q  <= 1'b0;
                pdone_q <= 1'b0;
            end else begin
                if (wrap_step && capturing)                 round_q <= 1'b1;
                if (trig_go)                                trgd_q  <= 1'b1;
                if ((trig_go && zero_post) || post_end)     pdone_q <= 1'b1;
            end
            if (post_wr) post_rows <= post_wdata;
            if (trig_go)
                cnt <= post_rows;
            else if ((state == ST_POST) && !mode_wr && row_step)
                cnt <= cnt - POST_W'(1);
        end
    end
endmodule

// File: rtl/capctl_pos_regs.sv
module capctl_pos_regs #(
    parameter int ADDR_W = 24,
    parameter int RS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              trig_latch,
    input  logic              stop_latch,
    input  logic [7:0]        status,
    input  logic [RS_W-1:0]   rd_sel,
    output logic [7:0]        rd_byte
);
    localparam int NB    = (ADDR_W + 7) / 8;
    localparam int SLOTS = 2 * NB + 1;

    logic [ADDR_W-1:0] trig_pos, stop_pos;
    logic [NB*8-1:0]   tpad, spad;
    logic [7:0]        slots [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_pos <= '0;
            stop_pos <= '0;
        end else begin
            if (trig_latch) trig_pos <= wr_addr;
            if (stop_latch) stop_pos <= wr_addr;
        end
    end

    assign tpad = (NB*8)'(trig_pos);
    assign spad = (NB*8)'(stop_pos);

    for (genvar k = 0; k < NB; k++) begin : g_bytes
        assign slots[k]      = tpad[8*k +: 8];
        assign slots[NB + k] = spad[8*k +: 8];
    end
    assign slots[2*NB] = status;

    always_comb begin
        rd_byte = 8'h00;
        for (int i = 0; i < SLOTS; i++)
            if (int'(rd_sel) == i) rd_byte = slots[i];
    end
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl #(
    parameter int ADDR_W = 24,
    parameter int EVT_W  = 9,
    parameter int POST_W = ADDR_W - EVT_W,
    parameter int RS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [7:0]        mode_wdata,
    input  logic              post_wr,
    input  logic [POST_W-1:0] post_wdata,
    input  logic              trig_hit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [RS_W-1:0]   rd_sel,
    output logic [7:0]        rd_byte,
    output logic [7:0]        status,
    output logic              mem_wr_en,
    output logic              mem_rd_en,
    output logic              mem_init
);
    logic row_step, wrap_step, trig_latch, stop_latch;

    capctl_addr_watch #(.ADDR_W(ADDR_W), .EVT_W(EVT_W)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_addr   (wr_addr),
        .row_step  (row_step),
        .wrap_step (wrap_step)
    );

    capctl_fsm #(.POST_W(POST_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .post_wr    (post_wr),
        .post_wdata (post_wdata),
        .trig_hit   (trig_hit),
        .row_step   (row_step),
        .wrap_step  (wrap_step),
        .mem_wr_en  (mem_wr_en),
        .mem_rd_en  (mem_rd_en),
        .mem_init   (mem_init),
        .status     (status),
        .trig_latch (trig_latch),
        .stop_latch (stop_latch)
    );

    capctl_pos_regs #(.ADDR_W(ADDR_W), .RS_W(RS_W)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_addr    (wr_addr),
        .trig_latch (trig_latch),
        .stop_latch (stop_latch),
        .status     (status),
        .rd_sel     (rd_sel),
        .rd_byte    (rd_byte)
    );
endmodule

// File: rtl/capctl_chk.sv
module capctl_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_wr,
    input logic [7:0]        mode_wdata,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        status,
    input logic              mem_wr_en,
    input logic              mem_init
);
    // R5
    force_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_wdata[4]) |=> !mem_wr_en);

    // R7
    trig_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[5]) |-> $past(mode_wr && mode_wdata[2]));

    // R4
    post_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> status[5]);

    // R8
    init_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_init |-> $past(mode_wr && mode_wdata[7]));

    // R6
    wrap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> ($past(wr_addr) == '0));

    // R2
    zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status[2] && !status[7]);
endmodule

bind capture_ctrl capctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .wr_addr    (wr_addr),
    .status     (status),
    .mem_wr_en  (mem_wr_en),
    .mem_init   (mem_init)
);

// File: tb/capture_ctrl_tb.sv
`timescale 1ns/1ps
module capture_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_wdata = '0;
    logic        post_wr = 1'b0;
    logic [14:0] post_wdata = '0;
    logic        trig_hit = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [2:0]  rd_sel = '0;
    logic [7:0]  rd_byte, status;
    logic        mem_wr_en, mem_rd_en, mem_init;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    capture_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .post_wr(post_wr), .post_wdata(post_wdata), .trig_hit(trig_hit),
        .wr_addr(wr_addr), .rd_sel(rd_sel), .rd_byte(rd_byte), .status(status),
        .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en), .mem_init(mem_init)
    );

    // {mode byte written, expected status afterwards}
    localparam logic [15:0] VEC [10] = '{
        {8'h01, 8'h01}, {8'h09, 8'h09}, {8'h0B, 8'h0B}, {8'h2B, 8'h6A},
        {8'h04, 8'h00}, {8'h45, 8'h01}, {8'h11, 8'h00}, {8'h01, 8'h01},
        {8'h21, 8'h01}, {8'h80, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic mode_write(input logic [7:0] v);
        @(negedge clk);
        mode_wr = 1'b1;
        mode_wdata = v;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic set_addr(input logic [23:0] a);
        @(negedge clk);
        wr_addr = a;
        @(negedge clk);
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        trig_hit = 1'b1;
        @(negedge clk);
        trig_hit = 1'b0;
    endtask

    task automatic read_pos(input string tag, input int base, input logic [23:0] exp);
        for (int b = 0; b < 3; b++) begin
            rd_sel = 3'(base + b);
            #1;
            check(tag, {24'h0, rd_byte}, {24'h0, exp[8*b +: 8]});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", {24'h0, status}, 32'h0);
        check("R1 mem_wr_en", {31'h0, mem_wr_en}, 32'h0);
        check("R1 mem_rd_en", {31'h0, mem_rd_en}, 32'h0);
        check("R1 mem_init", {31'h0, mem_init}, 32'h0);
        read_pos("R1 trig pos", 0, 24'h0);
        read_pos("R1 stop pos", 3, 24'h0);

        // R2 R3 R5 R7 mode sequence table
        wr_addr = 24'h000010;
        for (int i = 0; i < 10; i++) begin
            mode_write(VEC[i][15:8]);
            check($sformatf("R2 table step %0d status", i), {24'h0, status}, {24'h0, VEC[i][7:0]});
        end

        // R4 post-trigger countdown of two rows
        @(negedge clk);
        post_wr = 1'b1; post_wdata = 15'd2;
        @(negedge clk);
        post_wr = 1'b0;
        set_addr(24'h000105);
        mode_write(8'h09);
        check("R3 armed", {24'h0, status}, 32'h09);
        pulse_trig();
        check("R3 triggered", {24'h0, status}, 32'h29);
        read_pos("R3 trig pos", 0, 24'h000105);
        @(negedge clk);
        wr_addr = 24'h0001FF; trig_hit = 1'b1;
        @(negedge clk);
        trig_hit = 1'b0;
        read_pos("R3 retrigger ignored", 0, 24'h000105);
        check("R4 same row no step", {24'h0, status}, 32'h29);
        set_addr(24'h000200);
        @(negedge clk);
        check("R4 one row left", {24'h0, status}, 32'h29);
        set_addr(24'h000400);
        check("R4 countdown done", {24'h0, status}, 32'h68);
        check("R4 write stopped", {31'h0, mem_wr_en}, 32'h0);
        read_pos("R4 stop pos", 3, 24'h000400);

        // R5 force stop
        set_addr(24'h123456);
        mode_write(8'h05);
        check("R7 flags cleared", {24'h0, status}, 32'h01);
        mode_write(8'h11);
        check("R5 status", {24'h0, status}, 32'h00);
        check("R5 mem_wr_en", {31'h0, mem_wr_en}, 32'h0);
        read_pos("R5 stop pos", 3, 24'h123456);

        // R6 wrap
        mode_write(8'h01);
        set_addr(24'hFFFFFF);
        check("R6 no wrap yet", {24'h0, status}, 32'h01);
        set_addr(24'h000000);
        check("R6 wrapped", {24'h0, status}, 32'h11);
        pulse_trig();
        check("R3 trig disabled ignored", {24'h0, status}, 32'h11);
        read_pos("R3 trig pos kept", 0, 24'h000105);
        mode_write(8'h05);
        check("R7 round cleared", {24'h0, status}, 32'h01);
        mode_write(8'h00);
        set_addr(24'hFFFFFF);
        set_addr(24'h000000);
        check("R6 idle wrap ignored", {24'h0, status}, 32'h00);

        // R8 init pulse
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = 8'h80;
        @(negedge clk);
        mode_wr = 1'b0;
        check("R8 init high", {31'h0, mem_init}, 32'h1);
        @(negedge clk);
        check("R8 init low", {31'h0, mem_init}, 32'h0);

        // R9 readback, R2 read enable and unused bit
        mode_write(8'h42);
        check("R2 read enable", {31'h0, mem_rd_en}, 32'h1);
        rd_sel = 3'd6; #1;
        check("R9 status slot", {24'h0, rd_byte}, 32'h02);
        rd_sel = 3'd7; #1;
        check("R9 spare slot", {24'h0, rd_byte}, 32'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule